// File: doc/BRIEF.md
# Retrace Feature-Mode Detector

This block watches a digitized luminance stream during the vertical retrace interval. It decides whether the source puts back flat retrace levels instead of carrying the real sync and retrace activity. A paused tape source is the typical case. When a source does this, a noise estimate taken from the retrace lines cannot be trusted. Downstream control logic reads the registered flag and either ignores or discounts that estimate.

Each field begins with a vertical strobe, which sets a line index to zero. Each horizontal strobe then advances the index by one. Two fixed lines form the observation window. Inside these lines, a step between adjacent samples that is larger than a programmable threshold counts as a transient. At the end of the window the block makes one decision for the field. A field with a transient clears the flag and the quiet-field count. A quiet field advances the count. After three consecutive quiet fields the flag is set. The flag is also exported as the top bit of a status byte. The other bits of that byte are reserved for the noise value and stay zero here.

Top module: `retrace_fm_detect`

## Requirements
- R1: A transient is a sample whose absolute difference from the previous sample of the same observed line is strictly greater than `thresh`. The first sample after a horizontal or vertical strobe is never compared, and a difference exactly equal to `thresh` is not a transient.
- R2: `vsync` sets the line index to 0 and each `hsync` adds one. Only samples on line indices OBS_FIRST and OBS_FIRST+1 (3 and 4 by default) are examined, and strobe cycles are excluded. Transients on any other line have no effect on `fm`.
- R3: `fm` becomes 1 at the decision of the QUIET_FIELDS-th (default 3) consecutive quiet field, and not before.
- R4: A field with a transient in its observed lines clears the quiet count to 0 and drives `fm` to 0 at that field's decision.
- R5: The decision is taken on the `hsync` cycle that ends line OBS_FIRST+1, and `fm` changes only on the clock edge of that cycle. A field that a new `vsync` cuts off before this point makes no decision, leaves the count unchanged, and any transient it held is discarded.
- R6: After reset `fm` is 0 and the quiet count is 0.
- R7: `nd_status` carries `fm` in bit 7, and bits 6 to 0 are zero.
- R8: Once set, `fm` stays 1 through further quiet fields, because the count saturates.
- R9: `thresh` is sampled live. Raising it above a step makes that step quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample | input | DW | Luminance sample, one per clock |
| hsync | input | 1 | One-cycle strobe at the start of each line |
| vsync | input | 1 | One-cycle strobe at the start of each field (line 0) |
| thresh | input | DW | Transient threshold |
| fm | output | 1 | Registered flat-retrace flag |
| nd_status | output | 8 | Status byte with `fm` in bit 7 |

## Verification
The bench targets the following corner cases. A step exactly at the threshold must not count; a design using `>=` would clear the flag on such a field. A level change that lands across a horizontal strobe must not count; a design that keeps the previous sample across lines would report a false transient. Transients on lines just outside the window must be ignored; an off-by-one window would reset the count. A field cut short by an early vertical strobe, with a transient in its last observed line, must neither advance nor reset the count; a design that decides on `vsync` or keeps the pending hit would change when the flag rises.

// File: rtl/retrace_fm_detect.sv
module retrace_fm_detect #(
  parameter int DW           = 8,
  parameter int LINE_W       = 10,
  parameter int OBS_FIRST    = 3,
  parameter int OBS_LINES    = 2,
  parameter int QUIET_FIELDS = 3,
  localparam int QW          = $clog2(QUIET_FIELDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sample,
  input  logic          hsync,
  input  logic          vsync,
  input  logic [DW-1:0] thresh,
  output logic          fm,
  output logic [7:0]    nd_status
);

  localparam logic [LINE_W-1:0] L_FIRST = LINE_W'(OBS_FIRST);
  localparam logic [LINE_W-1:0] L_LAST  = LINE_W'(OBS_FIRST + OBS_LINES - 1);
  localparam logic [LINE_W-1:0] L_MAX   = '1;
  localparam logic [QW-1:0]     Q_MAX   = QW'(QUIET_FIELDS);

  logic [LINE_W-1:0] line_idx;
  logic [DW-1:0]     prev_s;
  logic              prev_ok;
  logic              hit;
  logic [QW-1:0]     quiet_cnt;

  logic          in_win;
  logic          decide;
  logic [DW-1:0] diff;
  logic          transient;
  logic [QW-1:0] next_q;

  assign in_win    = (line_idx >= L_FIRST) && (line_idx <= L_LAST) && !hsync && !vsync;
  assign decide    = hsync && !vsync && (line_idx == L_LAST);
  assign diff      = (sample >= prev_s) ? (sample - prev_s) : (prev_s - sample);
  assign transient = in_win && prev_ok && (diff > thresh);
  assign next_q    = (quiet_cnt == Q_MAX) ? Q_MAX : quiet_cnt + 1'b1;
  assign nd_status = {fm, 7'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_idx <= '0;
    end else if (vsync) begin
      line_idx <= '0;
    end else if (hsync && line_idx != L_MAX) begin
      line_idx <= line_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s  <= '0;
      prev_ok <= 1'b0;
    end else if (hsync || vsync) begin
      prev_ok <= 1'b0;
    end else if (in_win) begin
      prev_s  <= sample;
      prev_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hit <= 1'b0;
    else if (vsync || decide) hit <= 1'b0;
    else if (transient)       hit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      fm        <= 1'b0;
    end else if (decide) begin
      quiet_cnt <= hit ? '0 : next_q;
      fm        <= !hit && (next_q == Q_MAX);
    end
  end

  p_hit_clears_fm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    decide && hit |=> !fm && quiet_cnt == '0);

  p_fm_needs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fm |-> quiet_cnt == Q_MAX);

  p_fm_moves_at_decision_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fm) |-> $past(decide));

  p_hit_from_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(in_win));

  p_count_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quiet_cnt) |-> $past(decide));

endmodule

// File: tb/retrace_fm_detect_test.sv
module retrace_fm_detect_test;
  localparam int LEN   = 16;
  localparam int NLINE = 7;
  localparam logic [7:0] B = 8'd100;

  typedef enum int {K_QUIET, K_T1, K_T2, K_OUT, K_EQ, K_BND, K_HI, K_SHORT} kind_t;
  typedef struct { logic fm; string tag; } exp_t;

  logic clk = 0, rst_n = 0, hsync = 0, vsync = 0;
  logic [7:0] sample = B, thresh = 8'd10;
  logic fm;
  logic [7:0] nd_status;

  int checks = 0, fails = 0, qc = 0;
  logic exp_fm = 0;
  exp_t q[$];
  event ev_chk;

  retrace_fm_detect uut (.clk(clk), .rst_n(rst_n), .sample(sample), .hsync(hsync),
    .vsync(vsync), .thresh(thresh), .fm(fm), .nd_status(nd_status));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] ex);
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, ex);
    end
  endtask

  initial begin
    forever begin
      @(ev_chk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {7'd0, fm}, {7'd0, e.fm});
        check({e.tag, " R7 status"}, nd_status, {e.fm, 7'd0});
      end
    end
  end

  task automatic tick(input logic [7:0] s, input logic h, input logic v);
    sample = s; hsync = h; vsync = v;
    @(negedge clk);
  endtask

  function automatic logic [7:0] pix(kind_t k, int ln, int i);
    case (k)
      K_T1:  return (ln == 3 && i == 6) ? 8'd150 : B;
      K_T2:  return (ln == 4 && i == 9) ? 8'd150 : B;
      K_OUT: return ((ln == 2 || ln == 5) && i == 5) ? 8'd150 : B;
      K_EQ:  return (ln == 3 && i >= 6) ? 8'd110 : ((ln == 4 && i >= 6) ? 8'd90 : B);
      K_BND: return (ln == 4) ? 8'd160 : B;
      K_HI:  return (ln == 3 && i == 6) ? 8'd150 : B;
      K_SHORT: return (ln == 4 && i == 3) ? 8'd200 : B;
      default: return B;
    endcase
  endfunction

  task automatic field(input kind_t k, input string tag);
    logic hit_f;
    hit_f = (k == K_T1 || k == K_T2);
    tick(B, 1'b0, 1'b1);
    for (int ln = 0; ln < NLINE; ln++) begin
      if (ln > 0) tick(B, 1'b1, 1'b0);
      if (ln == 5) begin
        if (hit_f) begin qc = 0; exp_fm = 0; end
        else begin if (qc < 3) qc++; exp_fm = (qc >= 3); end
        q.push_back('{exp_fm, tag});
        -> ev_chk;
      end
      for (int i = 0; i < LEN - 1; i++) begin
        if (k == K_SHORT && ln == 4 && i == 5) begin
          q.push_back('{exp_fm, tag});
          -> ev_chk;
          return;
        end
        tick(pix(k, ln, i), 1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 fm after reset", {7'd0, fm}, 8'd0);
    check("R6 R7 status after reset", nd_status, 8'd0);
    rst_n = 1;
    @(negedge clk);
    field(K_QUIET, "R3 quiet 1");
    field(K_QUIET, "R3 quiet 2");
    field(K_QUIET, "R3 quiet 3 sets");
    field(K_QUIET, "R8 stays set");
    field(K_T1,    "R4 R1 transient line 3");
    field(K_QUIET, "R3 recount 1");
    field(K_QUIET, "R3 recount 2");
    field(K_T2,    "R4 transient line 4");
    field(K_QUIET, "R3 q1");
    field(K_QUIET, "R3 q2");
    field(K_QUIET, "R3 q3 sets");
    field(K_OUT,   "R2 outside window ignored");
    field(K_EQ,    "R1 step equal to threshold");
    field(K_BND,   "R1 step across hsync");
    thresh = 8'd60;
    field(K_HI,    "R9 raised threshold");
    thresh = 8'd10;
    field(K_T1,    "R9 R4 threshold restored");
    field(K_SHORT, "R5 cut-off field no decision");
    field(K_QUIET, "R5 after short q1");
    field(K_QUIET, "R5 q2");
    field(K_SHORT, "R5 cut-off field keeps count");
    field(K_QUIET, "R5 q3 sets");
    tick(B, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule